// File: doc/BRIEF.md
# Algebraic Right Shifter with Carry

This block shifts a 32-bit word right arithmetically, so the sign bit fills the vacated upper positions. Alongside the shifted word it produces a carry flag. The flag is set only when the source is negative and at least one 1 bit fell off the low end. This lets software tell when a signed division by a power of two rounded toward minus infinity instead of toward zero.

The amount comes from one of two places. In register mode it is the low six bits of a full-width operand, so it ranges from 0 to 63. Any amount of 32 or more saturates: the result becomes a copy of the sign in every bit, and the carry equals the sign. In immediate mode a five-bit field gives the amount directly.

When the record option is set, the block also classifies the result into a four-bit condition field: negative, positive or zero, plus a copy of the summary-overflow input. The datapath is combinational. A single register stage follows it, and a valid strobe marks the cycle in which the outputs carry a new result.

Top module: `sra_carry_unit`

## Requirements
- R1: In register mode only bits [5:0] of `in_amt_reg` form the shift amount; bits above bit 5 have no effect on the result or the carry.
- R2: For an amount of 0 to 31, `out_res` equals the source shifted right arithmetically by the amount, with the source's bit 31 filling the vacated bits.
- R3: In register mode with an amount of 32 to 63, every bit of `out_res` equals bit 31 of the source.
- R4: In register mode with an amount of 32 to 63, `out_carry` equals bit 31 of the source.
- R5: For an amount of 0 to 31, `out_carry` is 1 exactly when source bit 31 is 1 and the source bits below the amount position (the bits shifted out) are not all zero.
- R6: In immediate mode (`in_mode` = 1) the amount is `in_imm` (0 to 31), and `in_amt_reg` has no effect.
- R7: An amount of zero returns the source unchanged with `out_carry` = 0.
- R8: With `in_rec` = 1, `out_cond` bit 3 flags a negative result, bit 2 a positive non-zero result and bit 1 a zero result (exactly one of the three is set), and bit 0 copies `in_so`.
- R9: With `in_rec` = 0, `out_cond` is 0.
- R10: `out_valid` is `in_valid` delayed by one clock. `out_res`, `out_carry` and `out_cond` change only in the cycle after `in_valid` was high; otherwise they hold.
- R11: While `rst_n` is low, `out_valid`, `out_res`, `out_carry` and `out_cond` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_src | input | 32 | Word to shift |
| in_amt_reg | input | 32 | Register operand; low six bits give the amount in register mode |
| in_imm | input | 5 | Immediate amount |
| in_mode | input | 1 | 0 = register amount, 1 = immediate amount |
| in_rec | input | 1 | Record option: produce the condition field |
| in_so | input | 1 | Stored summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_res | output | 32 | Shifted word |
| out_carry | output | 1 | Carry flag |
| out_cond | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
The bench targets several boundaries. Amounts 31 and 32 sit on either side of the saturation limit; a design that only masked to five bits would wrap 32 to a shift of zero. Register operands carry junk above bit 5, which catches any design that compares the whole operand. The carry is tested with negative sources whose lost bits are all zero (such as 0x80000000 shifted by 31), with a single 1 in the lowest lost position, and with positive sources. An off-by-one mask would set the carry on a kept bit or miss the lowest lost bit, and a design that dropped the sign term would raise carry on positive inputs. Immediate mode is driven with register operands above 31 to catch a mode select that still saturates, and the condition field is checked on negative, positive and zero results with and without the record option.

// File: rtl/sra_pkg.sv
package sra_pkg;

   typedef enum logic {
      AMT_FROM_REG = 1'b0,
      AMT_FROM_IMM = 1'b1
   } amt_src_e;

   typedef struct packed {
      logic neg;
      logic pos;
      logic zero;
      logic so;
   } cond_t;

endpackage

// File: rtl/sra_amt_sel.sv
module sra_amt_sel
   import sra_pkg::*;
#(
   parameter  int DATA_W = 32,
   localparam int SHW    = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] amt_reg,
   input  logic [SHW-1:0]    amt_imm,
   input  amt_src_e          mode,
   output logic [SHW-1:0]    amt,
   output logic              sat
);

   localparam int REG_AMT_W = SHW + 1;

   logic [REG_AMT_W-1:0] reg_amt;
   logic                 unused_hi;

   // mask the register operand down to one bit more than the shift index
   assign reg_amt   = amt_reg[REG_AMT_W-1:0];
   assign unused_hi = ^amt_reg[DATA_W-1:REG_AMT_W];

   always_comb begin
      if (mode == AMT_FROM_IMM) begin
         amt = amt_imm;
         sat = 1'b0;
      end else begin
         amt = reg_amt[SHW-1:0];
         sat = reg_amt[SHW];
      end
   end

endmodule

// File: rtl/sra_core.sv
module sra_core #(
   parameter  int DATA_W = 32,
   localparam int SHW    = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src,
   input  logic [SHW-1:0]    amt,
   input  logic              sat,
   output logic [DATA_W-1:0] res,
   output logic              carry
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   logic              sign;
   logic [DATA_W-1:0] lost_mask;
   logic [DATA_W-1:0] shifted;
   logic              lost_ones;

   assign sign      = src[DATA_W-1];
   assign lost_mask = (ONE << amt) - ONE;
   assign shifted   = DATA_W'($signed(src) >>> amt);
   assign lost_ones = |(src & lost_mask);

   always_comb begin
      if (sat) begin
         res   = {DATA_W{sign}};
         carry = sign;
      end else begin
         res   = shifted;
         carry = sign & lost_ones;
      end
   end

endmodule

// File: rtl/sra_cond_gen.sv
module sra_cond_gen
   import sra_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] res,
   input  logic              rec,
   input  logic              so,
   output cond_t             cond
);

   logic is_neg;
   logic is_zero;

   assign is_neg  = res[DATA_W-1];
   assign is_zero = (res == '0);

   always_comb begin
      cond = '0;
      if (rec) begin
         cond.neg  = is_neg;
         cond.pos  = ~is_neg & ~is_zero;
         cond.zero = is_zero;
         cond.so   = so;
      end
   end

endmodule

// File: rtl/sra_carry_unit.sv
module sra_carry_unit
   import sra_pkg::*;
#(
   parameter  int DATA_W      = 32,
   parameter  bit ENABLE_COND = 1'b1,
   localparam int SHW         = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_src,
   input  logic [DATA_W-1:0] in_amt_reg,
   input  logic [SHW-1:0]    in_imm,
   input  logic              in_mode,
   input  logic              in_rec,
   input  logic              in_so,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_res,
   output logic              out_carry,
   output logic [3:0]        out_cond
);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("sra_carry_unit: DATA_W must be a power of two of at least 8");
      end
   endgenerate

   logic [SHW-1:0]    amt;
   logic              sat;
   logic [DATA_W-1:0] res_d;
   logic              carry_d;
   cond_t             cond_d;

   sra_amt_sel #(.DATA_W(DATA_W)) u_amt_sel (
      .amt_reg (in_amt_reg),
      .amt_imm (in_imm),
      .mode    (amt_src_e'(in_mode)),
      .amt     (amt),
      .sat     (sat)
   );

   sra_core #(.DATA_W(DATA_W)) u_core (
      .src   (in_src),
      .amt   (amt),
      .sat   (sat),
      .res   (res_d),
      .carry (carry_d)
   );

   generate
      if (ENABLE_COND) begin : g_cond
         sra_cond_gen #(.DATA_W(DATA_W)) u_cond (
            .res  (res_d),
            .rec  (in_rec),
            .so   (in_so),
            .cond (cond_d)
         );
      end else begin : g_no_cond
         logic unused_cond_in;
         assign unused_cond_in = in_rec ^ in_so;
         assign cond_d         = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_res   <= '0;
         out_carry <= 1'b0;
         out_cond  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_res   <= res_d;
            out_carry <= carry_d;
            out_cond  <= cond_d;
         end
      end
   end

endmodule

// File: rtl/sra_carry_chk.sv
module sra_carry_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_mode,
   input logic              amt_hi,
   input logic              in_rec,
   input logic              in_so,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_res,
   input logic              out_carry,
   input logic [3:0]        out_cond
);

   // R10
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R10
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R10
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_res) && $stable(out_carry) && $stable(out_cond)));

   // R3
   sat_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_mode && amt_hi) |=> (out_res == '0 || out_res == '1));

   // R4
   sat_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_mode && amt_hi) |=> (out_carry == out_res[DATA_W-1]));

   // R5
   carry_neg_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!out_carry || out_res[DATA_W-1]));

   // R8
   cond_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_rec) |=> ($countones(out_cond[3:1]) == 1));

   // R8
   cond_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_rec) |=> (out_cond[0] == $past(in_so)));

   // R9
   cond_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_rec) |=> (out_cond == 4'b0000));

endmodule

bind sra_carry_unit sra_carry_chk #(.DATA_W(DATA_W)) u_sra_carry_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_mode   (in_mode),
   .amt_hi    (in_amt_reg[SHW]),
   .in_rec    (in_rec),
   .in_so     (in_so),
   .out_valid (out_valid),
   .out_res   (out_res),
   .out_carry (out_carry),
   .out_cond  (out_cond)
);

// File: tb/sra_carry_unit_bench.sv
module sra_carry_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] in_src;
   logic [31:0] in_amt_reg;
   logic [4:0]  in_imm;
   logic        in_mode;
   logic        in_rec;
   logic        in_so;
   logic        out_valid;
   logic [31:0] out_res;
   logic        out_carry;
   logic [3:0]  out_cond;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   sra_carry_unit u_sra_carry_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_src     (in_src),
      .in_amt_reg (in_amt_reg),
      .in_imm     (in_imm),
      .in_mode    (in_mode),
      .in_rec     (in_rec),
      .in_so      (in_so),
      .out_valid  (out_valid),
      .out_res    (out_res),
      .out_carry  (out_carry),
      .out_cond   (out_cond)
   );

   function automatic logic [5:0] model_amt(input logic [31:0] r, input logic [4:0] i,
                                            input logic m);
      return m ? {1'b0, i} : r[5:0];
   endfunction

   function automatic logic [31:0] model_res(input logic [31:0] s, input logic [5:0] a);
      logic [31:0] v;
      if (a > 6'd31) return {32{s[31]}};
      v = s;
      for (int k = 0; k < 32; k++) if (k < int'(a)) v = {s[31], v[31:1]};
      return v;
   endfunction

   function automatic logic model_carry(input logic [31:0] s, input logic [5:0] a);
      logic lost;
      if (a > 6'd31) return s[31];
      lost = 1'b0;
      for (int k = 0; k < 32; k++) if (k < int'(a) && s[k]) lost = 1'b1;
      return s[31] & lost;
   endfunction

   function automatic logic [3:0] model_cond(input logic [31:0] r, input logic rec,
                                             input logic so);
      if (!rec) return 4'b0000;
      if (r[31]) return {3'b100, so};
      if (r == 32'd0) return {3'b001, so};
      return {3'b010, so};
   endfunction

   task automatic check(input logic ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one operation, then compare after the register stage
   task automatic run_op(input logic [31:0] s, input logic [31:0] r, input logic [4:0] i,
                         input logic m, input logic rec, input logic so, input string tag);
      logic [5:0]  a;
      logic [31:0] er;
      logic        ec;
      logic [3:0]  eq;
      a  = model_amt(r, i, m);
      er = model_res(s, a);
      ec = model_carry(s, a);
      eq = model_cond(er, rec, so);
      @(negedge clk);
      in_valid = 1'b1; in_src = s; in_amt_reg = r; in_imm = i;
      in_mode = m; in_rec = rec; in_so = so;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b1, {tag, " R10 valid"}, {31'd0, out_valid}, 32'd1);
      check(out_res === er, {tag, " result"}, out_res, er);
      check(out_carry === ec, {tag, " carry"}, {31'd0, out_carry}, {31'd0, ec});
      check(out_cond === eq, {tag, " cond"}, {28'd0, out_cond}, {28'd0, eq});
   endtask

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] hold_res;
      logic        hold_carry;
      logic [3:0]  hold_cond;
      void'($urandom(32'd20050721));
      rst_n = 1'b0; in_valid = 1'b0; in_src = '0; in_amt_reg = '0;
      in_imm = '0; in_mode = 1'b0; in_rec = 1'b0; in_so = 1'b0;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(out_valid === 1'b0 && out_res === 32'd0 && out_carry === 1'b0 &&
            out_cond === 4'd0, "R11 reset", out_res, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 amount zero passes source, carry 0
      run_op(32'hF000_0001, 32'd0, 5'd0, 1'b0, 1'b1, 1'b0, "R7 zero reg");
      run_op(32'h8000_0003, 32'd0, 5'd0, 1'b1, 1'b0, 1'b0, "R7 zero imm");
      // R5 lowest lost bit, no lost bits, positive source
      run_op(32'h8000_0001, 32'd1, 5'd0, 1'b0, 1'b0, 1'b0, "R5 lost one");
      run_op(32'h8000_0000, 32'd31, 5'd0, 1'b0, 1'b1, 1'b1, "R5 clean lost");
      run_op(32'h7FFF_FFFF, 32'd31, 5'd0, 1'b0, 1'b1, 1'b0, "R5 positive");
      run_op(32'hFFFF_FFF0, 32'd4, 5'd0, 1'b0, 1'b0, 1'b0, "R5 mask edge");
      run_op(32'hFFFF_FFF0, 32'd5, 5'd0, 1'b0, 1'b0, 1'b0, "R2 R5 mask edge+1");
      // R3 R4 saturation boundary
      run_op(32'h8000_1234, 32'd32, 5'd0, 1'b0, 1'b1, 1'b0, "R3 R4 neg 32");
      run_op(32'h4000_1234, 32'd32, 5'd0, 1'b0, 1'b1, 1'b1, "R3 R4 pos 32");
      run_op(32'hA5A5_A5A5, 32'd63, 5'd0, 1'b0, 1'b0, 1'b0, "R3 R4 neg 63");
      // R1 upper bits of the register operand ignored
      run_op(32'h8000_00F0, 32'hFFFF_FFC4, 5'd0, 1'b0, 1'b0, 1'b0, "R1 junk hi 4");
      run_op(32'h8000_00F0, 32'h0000_0140, 5'd0, 1'b0, 1'b1, 1'b0, "R1 junk hi 0");
      // R6 immediate mode ignores register operand
      run_op(32'h8000_0011, 32'd40, 5'd4, 1'b1, 1'b1, 1'b1, "R6 imm 4");
      run_op(32'hC000_0000, 32'hFFFF_FFFF, 5'd31, 1'b1, 1'b0, 1'b0, "R6 imm 31");
      // R8 zero class, R9 record off
      run_op(32'h0000_000F, 32'd4, 5'd0, 1'b0, 1'b1, 1'b1, "R8 zero result");
      run_op(32'h0000_0100, 32'd4, 5'd0, 1'b0, 1'b0, 1'b1, "R9 rec off");

      // R10 outputs hold while in_valid is low
      hold_res = out_res; hold_carry = out_carry; hold_cond = out_cond;
      @(negedge clk);
      in_src = 32'h8765_4321; in_amt_reg = 32'd3; in_rec = 1'b1; in_so = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b0, "R10 idle valid", {31'd0, out_valid}, 32'd0);
      check(out_res === hold_res && out_carry === hold_carry && out_cond === hold_cond,
            "R10 hold", out_res, hold_res);

      // R2 R5 R8 random mix
      for (int n = 0; n < 400; n++) begin
         logic [31:0] s;
         logic [31:0] r;
         s = $urandom();
         r = $urandom();
         if (n % 4 == 0) s = s & 32'hFFFF_0000;
         run_op(s, r, 5'($urandom()), 1'($urandom()), 1'($urandom()),
                1'($urandom()), "R2 random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule